// File: doc/BRIEF.md
# E1 Receive Highway Timing Generator

This block produces the receive-side timing of an E1 system highway. A free-running clock counter marks each clock of the 125 µs frame. It derives the timeslot number and the bit number, shifts each timeslot's byte onto a serial data line, and raises a frame marker at a bit position that software chooses.

The highway clock is either 2.048 MHz or 8.192 MHz, and the data rate is either 2.048 or 4.096 Mbit/s. When the clock is 8.192 MHz, every bit cell is split into channel phases. Several devices can then share one highway wire, because each one drives only during its own phase. A frame sync pulse places the frame start, and a programmable offset delays that start. Without sync pulses the counter wraps on its own at the frame length. Each output changes on the falling edge of the system clock. Each input is sampled on the falling edge.

Top module: `rx_hwy_timing`

## Requirements
- R1: The settings {slow clock (`fast_clk_i`=0), 2.048 Mbit/s}, {fast clock, 2.048 Mbit/s} and {fast clock, 4.096 Mbit/s} are valid. The setting `fast_clk_i`=0 with `dbl_rate_i`=1 is invalid. While it is applied, `dout_oe_o`, `dout_o` and `mark_o` stay low, and `cfg_err_o` goes high at the next falling edge. `cfg_err_o` then stays high until reset, even after a valid setting returns.
- R2: A frame is 256 clocks with the slow clock and 1024 clocks with the fast clock. When no sync arrives, the frame start repeats every frame length.
- R3: Suppose `sync_i` is sampled high at a falling edge, and let k be `frm_ofs_i` modulo the frame length (only the low 8 bits count with the slow clock). Timeslot 0, bit 0 then begins exactly k falling edges after that edge (k=0: at that same edge).
- R4: One bit lasts 1 clock (slow), 4 clocks (fast, 2.048 Mbit/s) or 2 clocks (fast, 4.096 Mbit/s). `ts_o` is the frame bit index divided by 8, and `bit_o` is that index modulo 8. A 4.096 Mbit/s frame has 512 bits (timeslots 0 to 63). The other modes have 256 bits (timeslots 0 to 31).
- R5: The phase is the clock index within the bit cell. With the fast clock at 2.048 Mbit/s, `dout_oe_o` is high only where the phase (0 to 3) equals `phase_sel_i`. At 4.096 Mbit/s it is high only where the phase (0 to 1) equals `phase_sel_i[0]`. With the slow clock it is always high.
- R6: `slot_byte_i` is captured at the edge that enters the first clock of a timeslot, and it is sent MSB first: `bit_o`=n carries byte bit 7-n. `dout_o` is 0 whenever `dout_oe_o` is low.
- R7: `mark_o` is high for the whole bit cell whose frame bit index equals `mark_pos_i` (9 bits). That is 1, 4 or 2 clocks per frame in the three valid modes. At 2.048 Mbit/s a value of 256 or more never matches.
- R8: With `mark_en_i` low, `mark_o` stays low.
- R9: Reset (active low, asynchronous) clears the counter to frame clock 0, clears the latched byte and clears `cfg_err_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System highway clock, active on the falling edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sync_i | input | 1 | Frame sync pulse |
| fast_clk_i | input | 1 | 1: 8.192 MHz clock, 0: 2.048 MHz clock |
| dbl_rate_i | input | 1 | 1: 4.096 Mbit/s data, 0: 2.048 Mbit/s |
| frm_ofs_i | input | 10 | Frame start delay after sync, in clocks |
| phase_sel_i | input | 2 | Channel phase that drives the highway |
| mark_en_i | input | 1 | Enables the frame marker output |
| mark_pos_i | input | 9 | Frame bit index that carries the marker |
| slot_byte_i | input | 8 | Byte for the timeslot that is starting |
| ts_o | output | 6 | Current timeslot number |
| bit_o | output | 3 | Current bit within the timeslot |
| dout_o | output | 1 | Serial highway data |
| dout_oe_o | output | 1 | Drive enable for dout_o; low means high impedance |
| mark_o | output | 1 | Frame marker, active high |
| cfg_err_o | output | 1 | Sticky invalid rate setting flag |

## Verification
The hardest cases are at the offset extremes. With offset 1023 on the fast clock, the counter is loaded with frame clock 1, so the frame start falls almost a whole frame after the sync pulse. The bench reaches this case by issuing one sync and then watching two full frames, which covers both the first start and the free-running repeat. The marker needs its own care, because its pulse can straddle the window that the bench observes. The bench therefore counts marker clocks over exactly one frame length, so that the width check holds wherever the pulse falls.

// File: rtl/rxh_pkg.sv
package rxh_pkg;
    localparam int SLOT_BITS   = 8;
    localparam int BASE_SLOTS  = 32;
    localparam int FAST_MUL    = 4;
    localparam int FRAME_BITS  = SLOT_BITS * BASE_SLOTS;
    localparam int CNT_W       = $clog2(FRAME_BITS * FAST_MUL);
    localparam int SLOW_W      = $clog2(FRAME_BITS);
    localparam int BITNUM_W    = CNT_W - 1;
    localparam int SUB_W       = $clog2(SLOT_BITS);
    localparam int TS_W        = BITNUM_W - SUB_W;
    localparam int PH_W        = $clog2(FAST_MUL);

    typedef enum logic [1:0] {
        MODE_SLOW         = 2'd0,
        MODE_FAST_SINGLE  = 2'd1,
        MODE_FAST_DOUBLE  = 2'd2,
        MODE_BAD          = 2'd3
    } mode_e;

    typedef struct packed {
        logic [BITNUM_W-1:0] bitnum;
        logic [PH_W-1:0]     phase;
    } pos_t;

    function automatic mode_e mode_of(input logic fast, input logic dbl);
        if (!fast) return dbl ? MODE_BAD : MODE_SLOW;
        return dbl ? MODE_FAST_DOUBLE : MODE_FAST_SINGLE;
    endfunction

    // Split a frame clock count into frame bit index and phase in the cell.
    function automatic pos_t locate(input logic [CNT_W-1:0] cnt, input mode_e mode);
        pos_t p;
        p = '0;
        case (mode)
            MODE_FAST_SINGLE: begin
                p.bitnum = BITNUM_W'(cnt[CNT_W-1:PH_W]);
                p.phase  = cnt[PH_W-1:0];
            end
            MODE_FAST_DOUBLE: begin
                p.bitnum = cnt[CNT_W-1:1];
                p.phase  = PH_W'(cnt[0]);
            end
            default: begin
                p.bitnum = BITNUM_W'(cnt[SLOW_W-1:0]);
            end
        endcase
        return p;
    endfunction
endpackage

// File: rtl/rxh_clock_counter.sv
module rxh_clock_counter
    import rxh_pkg::*;
#(
    parameter int W      = CNT_W,
    parameter int SLOW_B = SLOW_W
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         sync_i,
    input  logic         fast_i,
    input  logic [W-1:0] ofs_i,
    output logic [W-1:0] cnt_o,
    output logic [W-1:0] cnt_next_o
);
    localparam logic [W-1:0] SLOW_MASK = W'((1 << SLOW_B) - 1);

    typedef struct packed {
        logic [W-1:0] cnt;
    } cnt_st_t;

    cnt_st_t      st_d, st_q;
    logic [W-1:0] wrap_mask;

    always_comb begin
        wrap_mask = fast_i ? '1 : SLOW_MASK;
        st_d      = st_q;
        if (sync_i) begin
            // frame clock 0 lands ofs (mod length) edges after this one
            st_d.cnt = (W'(0) - ofs_i) & wrap_mask;
        end else begin
            st_d.cnt = (st_q.cnt + W'(1)) & wrap_mask;
        end
    end

    always_ff @(negedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign cnt_o      = st_q.cnt;
    assign cnt_next_o = st_d.cnt;

    // R2: free-running step, wraps at the frame length
    a_r2_free_wrap: assert property (@(negedge clk_i) disable iff (!rst_ni)
        (!sync_i && !fast_i) |=> (cnt_o == W'(($past(cnt_o) + W'(1)) & SLOW_MASK)));

    // R3: a sync with zero offset starts the frame at once
    a_r3_sync_zero_ofs: assert property (@(negedge clk_i) disable iff (!rst_ni)
        (sync_i && ofs_i == '0) |=> (cnt_o == '0));
endmodule

// File: rtl/rxh_slot_decode.sv
module rxh_slot_decode
    import rxh_pkg::*;
(
    input  logic [CNT_W-1:0]    cnt_i,
    input  mode_e               mode_i,
    input  logic [PH_W-1:0]     phase_sel_i,
    input  logic                mark_en_i,
    input  logic [BITNUM_W-1:0] mark_pos_i,
    output logic [TS_W-1:0]     ts_o,
    output logic [SUB_W-1:0]    bit_o,
    output logic                drive_o,
    output logic                mark_o
);
    pos_t pos;

    always_comb begin
        pos   = locate(cnt_i, mode_i);
        ts_o  = pos.bitnum[BITNUM_W-1:SUB_W];
        bit_o = pos.bitnum[SUB_W-1:0];
        case (mode_i)
            MODE_SLOW:         drive_o = 1'b1;
            MODE_FAST_SINGLE:  drive_o = (pos.phase == phase_sel_i);
            MODE_FAST_DOUBLE:  drive_o = (pos.phase[0] == phase_sel_i[0]);
            default:           drive_o = 1'b0;
        endcase
        mark_o = mark_en_i && (mode_i != MODE_BAD) && (pos.bitnum == mark_pos_i);
    end
endmodule

// File: rtl/rx_hwy_timing.sv
module rx_hwy_timing
    import rxh_pkg::*;
(
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 sync_i,
    input  logic                 fast_clk_i,
    input  logic                 dbl_rate_i,
    input  logic [CNT_W-1:0]     frm_ofs_i,
    input  logic [PH_W-1:0]      phase_sel_i,
    input  logic                 mark_en_i,
    input  logic [BITNUM_W-1:0]  mark_pos_i,
    input  logic [SLOT_BITS-1:0] slot_byte_i,
    output logic [TS_W-1:0]      ts_o,
    output logic [SUB_W-1:0]     bit_o,
    output logic                 dout_o,
    output logic                 dout_oe_o,
    output logic                 mark_o,
    output logic                 cfg_err_o
);
    typedef struct packed {
        logic [SLOT_BITS-1:0] slot_byte;
        logic                 err;
    } top_st_t;

    mode_e            mode;
    logic [CNT_W-1:0] cnt, cnt_next;
    pos_t             pos_next;
    logic             load_byte;
    logic             drive;
    top_st_t          st_d, st_q;

    assign mode = mode_of(fast_clk_i, dbl_rate_i);

    rxh_clock_counter #(.W(CNT_W), .SLOW_B(SLOW_W)) u_cnt (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .sync_i     (sync_i),
        .fast_i     (fast_clk_i),
        .ofs_i      (frm_ofs_i),
        .cnt_o      (cnt),
        .cnt_next_o (cnt_next)
    );

    rxh_slot_decode u_dec (
        .cnt_i       (cnt),
        .mode_i      (mode),
        .phase_sel_i (phase_sel_i),
        .mark_en_i   (mark_en_i),
        .mark_pos_i  (mark_pos_i),
        .ts_o        (ts_o),
        .bit_o       (bit_o),
        .drive_o     (drive),
        .mark_o      (mark_o)
    );

    always_comb begin
        pos_next  = locate(cnt_next, mode);
        load_byte = (pos_next.bitnum[SUB_W-1:0] == '0) && (pos_next.phase == '0);
        st_d      = st_q;
        if (load_byte) st_d.slot_byte = slot_byte_i;
        st_d.err = st_q.err | (mode == MODE_BAD);
    end

    always_ff @(negedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign dout_oe_o = drive;
    assign dout_o    = drive & st_q.slot_byte[SUB_W'(SLOT_BITS - 1) - bit_o];
    assign cfg_err_o = st_q.err;

    // R1: an invalid rate setting keeps the highway and marker silent
    a_r1_bad_cfg_quiet: assert property (@(negedge clk_i) disable iff (!rst_ni)
        (!fast_clk_i && dbl_rate_i) |-> (!dout_oe_o && !dout_o && !mark_o));

    // R1: the error flag never clears outside reset
    a_r1_err_sticky: assert property (@(negedge clk_i) disable iff (!rst_ni)
        cfg_err_o |=> cfg_err_o);

    // R6: no data bit leaks while the drive enable is low
    a_r6_dout_quiet: assert property (@(negedge clk_i) disable iff (!rst_ni)
        !dout_oe_o |-> !dout_o);
endmodule

// File: tb/rx_hwy_timing_tb.sv
module rx_hwy_timing_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sync = 1'b0, fast = 1'b0, dbl = 1'b0, men = 1'b0;
    logic [9:0] ofs = '0;
    logic [1:0] psel = '0;
    logic [8:0] mpos = '0;
    logic [7:0] sbyte = '0;
    logic [5:0] ts;
    logic [2:0] bt;
    logic       dout, oe, mark, err;
    int         tests_run = 0, tests_failed = 0;

    always #4 clk = ~clk;

    rx_hwy_timing u_dut (
        .clk_i(clk), .rst_ni(rst_n), .sync_i(sync), .fast_clk_i(fast),
        .dbl_rate_i(dbl), .frm_ofs_i(ofs), .phase_sel_i(psel),
        .mark_en_i(men), .mark_pos_i(mpos), .slot_byte_i(sbyte),
        .ts_o(ts), .bit_o(bt), .dout_o(dout), .dout_oe_o(oe),
        .mark_o(mark), .cfg_err_o(err)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        tests_run++;
        if (!ok) begin
            tests_failed++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        #1;
        // R9: counter at frame clock 0, byte and error cleared
        check(ts == 0 && bt == 0, "R9", "reset position", ts * 8 + bt, 0);
        check(err == 1'b0, "R9", "reset error flag", err, 0);
        check(oe == 1'b1 && dout == 1'b0, "R9", "reset slow drive/data", {oe, dout}, 2);
    endtask

    // One sync, then two whole frames compared clock by clock with a model.
    task automatic t_mode(input string tag, input bit f, input bit d, input int o,
                          input int ps, input int mp, input bit me, input logic [7:0] pat);
        int len, msk, om, c, bn, ph, cpb, mcount;
        bit known, exp_oe, exp_mk, exp_do;
        bit pos_bad, oe_bad, do_bad, mk_bad, st_a, st_b, pre_b;
        int pos_a, pos_e, oe_a, do_a, mk_a;
        len = f ? 1024 : 256;
        msk = len - 1;
        om  = o & msk;
        cpb = !f ? 1 : (d ? 2 : 4);
        @(posedge clk);
        fast = f; dbl = d; ofs = 10'(o); psel = 2'(ps); mpos = 9'(mp);
        men = me; sbyte = pat; sync = 1'b1;
        @(posedge clk);
        sync = 1'b0;
        c = (len - om) & msk;
        known = 0; pos_bad = 0; oe_bad = 0; do_bad = 0; mk_bad = 0;
        mcount = 0; st_a = 0; st_b = 0; pre_b = 1;
        pos_a = 0; pos_e = 0; oe_a = 0; do_a = 0; mk_a = 0;
        for (int n = 0; n < 2 * len; n++) begin
            #1;
            if (!f)      begin bn = c;      ph = 0;     end
            else if (d)  begin bn = c >> 1; ph = c & 1; end
            else         begin bn = c >> 2; ph = c & 3; end
            exp_oe = !f ? 1'b1 : (d ? (ph == (ps & 1)) : (ph == ps));
            exp_mk = me && (bn == mp);
            if (ph == 0 && (bn % 8) == 0) known = 1;
            exp_do = exp_oe && pat[7 - (bn % 8)];
            if ((ts * 8 + bt) != bn && !pos_bad) begin
                pos_bad = 1; pos_a = ts * 8 + bt; pos_e = bn;
            end
            if (oe != exp_oe && !oe_bad) begin oe_bad = 1; oe_a = oe; end
            if (known && dout != exp_do && !do_bad) begin do_bad = 1; do_a = dout; end
            if (mark != exp_mk && !mk_bad) begin mk_bad = 1; mk_a = mark; end
            if (n < len && mark) mcount++;
            if (n == om)           st_a  = (ts == 0 && bt == 0);
            if (n == om + len)     st_b  = (ts == 0 && bt == 0);
            if (n == om + len - 1) pre_b = (ts == 0 && bt == 0);
            @(posedge clk);
            c = (c + 1) & msk;
        end
        check(st_a, "R3", {tag, " frame start after sync"}, st_a, 1);
        check(st_b && !pre_b, "R2", {tag, " frame start repeats"}, {st_b, pre_b}, 2);
        check(!pos_bad, "R4", {tag, " bit index"}, pos_a, pos_e);
        check(!oe_bad, "R5", {tag, " phase drive window"}, oe_a, !oe_a);
        check(!do_bad, "R6", {tag, " serial data"}, do_a, !do_a);
        check(!mk_bad, "R7", {tag, " marker position"}, mk_a, !mk_a);
        check(mcount == ((me && (d || mp < 256)) ? cpb : 0), me ? "R7" : "R8",
              {tag, " marker width"}, mcount, (me && (d || mp < 256)) ? cpb : 0);
        check(err == 1'b0, "R1", {tag, " no error on valid mode"}, err, 0);
    endtask

    task automatic t_bad_cfg();
        bit noisy;
        noisy = 0;
        @(posedge clk);
        fast = 1'b0; dbl = 1'b1; men = 1'b1; mpos = 9'd3; sbyte = 8'hFF;
        for (int n = 0; n < 300; n++) begin
            #1;
            if (oe || dout || mark) noisy = 1;
            @(posedge clk);
        end
        check(!noisy, "R1", "invalid mode outputs silent", noisy, 0);
        check(err == 1'b1, "R1", "invalid mode raises error", err, 1);
        dbl = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        check(err == 1'b1, "R1", "error flag sticky", err, 1);
        check(oe == 1'b1, "R1", "valid mode drives again", oe, 1);
    endtask

    initial begin
        #(8 * 200000);
        tests_run++;
        tests_failed++;
        $display("FAIL R2 watchdog expired: actual 0 expected 1");
        $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
        $finish;
    end

    initial begin
        t_reset();
        t_mode("slow ofs0",     0, 0, 0,    0, 0,   1, 8'hA5);
        t_mode("slow ofs255",   0, 0, 255,  0, 255, 1, 8'h3C);
        t_mode("slow ofs300",   0, 0, 300,  0, 17,  1, 8'h81);
        t_mode("fast2 ofs0",    1, 0, 0,    0, 0,   1, 8'hC3);
        t_mode("fast2 ofs1023", 1, 0, 1023, 3, 255, 1, 8'h5A);
        t_mode("fast2 ph2",     1, 0, 77,   2, 100, 1, 8'hF0);
        t_mode("fast2 pos300",  1, 0, 9,    1, 300, 1, 8'h0F);
        t_mode("fast4 ofs0",    1, 1, 0,    0, 511, 1, 8'h96);
        t_mode("fast4 ofs1023", 1, 1, 1023, 1, 0,   1, 8'h69);
        t_mode("mark off",      1, 0, 5,    1, 40,  0, 8'hE7);
        t_bad_cfg();
        $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
        $finish;
    end
endmodule